// File: doc/BRIEF.md
# Top-Down Metric Ratio Unit

This performance-monitoring block sits beside a processor core. It counts issue slots in a slots counter that software can load. In parallel, four internal event counters count slots in four pipeline categories: retiring, bad speculation, frontend bound and backend bound. Software cannot load the internal counters. They only ever start from zero, and they are cleared only as a side effect of an access to the metrics register. Each cycle the core raises one strobe for a slot and one strobe for each category that gained a slot.

Software reads the metrics register through a small request/response port. A read does not return raw counts. It returns four byte fields, and each field is its category's count scaled to a fraction of the slots count: `(255 * category) / slots`. The four quotients are computed by bit-serial dividers, which start when the read request is accepted. A read of the metrics register also starts a new measurement interval, because it clears the slots counter and the internal counters. If any internal counter wraps, a sticky overflow flag is raised. Software clears the flag through a control register or by writing the metrics register.

Top module: `topdown_ratio_unit`

## Requirements
- R1: After a synchronous reset, every counter is zero, `ovf_flag` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The slots counter adds one in each cycle that `slot_inc` is high. A read of address 0 raises `rsp_valid` in the cycle after acceptance, with the count as it stood before the accepting edge.
- R3: A write to address 0 loads `req_wdata` into the slots counter. A slot strobe in the same cycle is dropped.
- R4: A read of address 1 returns the packed fields `{backend[31:24], frontend[23:16], bad_spec[15:8], retiring[7:0]}`. The strobe index is `cat_inc[0]` for retiring, `[1]` for bad speculation, `[2]` for frontend and `[3]` for backend. Each field is `floor(255*category/slots)`, using the counts captured at acceptance.
- R5: A field whose category count exceeds the slots count reads 0xFF.
- R6: When the captured slots count is zero, every field reads 0 and `rsp_valid` rises in the second cycle after acceptance.
- R7: Accepting a metrics read clears the slots counter and all four category counters. Strobes in the accepting cycle count toward the new interval.
- R8: A write to address 1 clears the four category counters and `ovf_flag`, and it leaves the slots counter unchanged. Category strobes in that cycle count toward the new interval.
- R9: `ovf_flag` goes high in the cycle after any category counter wraps from all-ones to zero. It stays high until cleared, and a wrap outranks a clear in the same cycle.
- R10: A write to address 2 with bit 0 set clears `ovf_flag`, and a write with bit 0 clear leaves it as it was. A read of address 2 returns the flag in bit 0, and a read of address 3 returns zero.
- R11: While a metrics division is in progress, `req_ready` is low and any request is ignored.
- R12: A slots count much larger than a category count gives a field of 0, for example slots 1000 with category 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_inc | input | 1 | One issue slot this cycle |
| cat_inc | input | 4 | Per-category slot strobes (0 retiring, 1 bad spec, 2 frontend, 3 backend) |
| req_valid | input | 1 | Register request present |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_addr | input | 2 | 0 slots, 1 metrics, 2 control, 3 unused |
| req_wdata | input | CNT_W | Write data |
| req_ready | output | 1 | Request accepted at the next edge when high |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | RSP_W | Read response data |
| ovf_flag | output | 1 | Sticky category-counter overflow flag |

## Verification
A metrics read clears the counters in the same cycle in which slot and category strobes keep arriving. The bench provokes this collision on purpose by raising strobes in the accepting cycle and during the division. It then judges the result by the next interval's slots read and metrics read, which must include exactly those strobes. A second collision is a category wrap in the same cycle as a control-register clear of the overflow flag. The bench forces this case and checks that the flag stays high.

// File: rtl/td_pkg.sv
package td_pkg;

    localparam int CAT_N     = 4;
    localparam int FIELD_W   = 8;
    localparam int ADDR_W    = 2;
    localparam int STEP_CNT  = FIELD_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_SLOTS   = 2'd0,
        REG_METRICS = 2'd1,
        REG_CTRL    = 2'd2,
        REG_NONE    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DIV  = 1'b1
    } unit_state_e;

    typedef struct packed {
        logic slots_wr;
        logic slots_rd;
        logic met_wr;
        logic met_rd;
        logic ctl_wr;
        logic ctl_rd;
        logic none_rd;
    } op_t;

    function automatic op_t decode_op(logic fire, logic wr, logic [ADDR_W-1:0] addr);
        op_t d;
        d = '0;
        if (fire) begin
            case (reg_sel_e'(addr))
                REG_SLOTS:   begin d.slots_wr = wr; d.slots_rd = !wr; end
                REG_METRICS: begin d.met_wr   = wr; d.met_rd   = !wr; end
                REG_CTRL:    begin d.ctl_wr   = wr; d.ctl_rd   = !wr; end
                default:     d.none_rd = !wr;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/td_event_counter.sv
module td_event_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    logic [W-1:0] cnt_q;

    // A clear restarts the count, but this cycle's strobe still lands in the new interval.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= W'(inc);
        end else if (inc) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt  = cnt_q;
    assign wrap = inc && !clr && (&cnt_q);

    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == W'($past(inc)));  // R7
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt_q == '0);  // R9

endmodule

// File: rtl/td_ratio_div.sv
module td_ratio_div
    import td_pkg::*;
#(
    parameter int W = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               ack,
    input  logic [W-1:0]       cat,
    input  logic [W-1:0]       slots,
    output logic               done,
    output logic [FIELD_W-1:0] quo
);

    localparam int NW = W + FIELD_W;

    logic               busy_q;
    logic [3:0]         idx_q;
    logic [W-1:0]       rem_q;
    logic [W-1:0]       den_q;
    logic [NW-1:0]      num_q;
    logic [FIELD_W-1:0] quo_q;

    logic [NW-1:0]      num_start;
    logic [3:0]         bit_pos;
    logic [W:0]         trial;
    logic               fits;

    assign num_start = {cat, {FIELD_W{1'b0}}} - {{FIELD_W{1'b0}}, cat};
    assign bit_pos   = idx_q - 4'd1;
    assign trial     = {rem_q, num_q[bit_pos]};
    assign fits      = trial >= {1'b0, den_q};

    // Restoring division: the top W bits of 255*cat are already below the
    // divisor whenever cat <= slots, so eight steps yield the whole quotient.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            num_q  <= '0;
            quo_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            den_q  <= slots;
            num_q  <= num_start;
            rem_q  <= num_start[NW-1:FIELD_W];
            if (slots == '0) begin
                idx_q <= '0;
                quo_q <= '0;
            end else if (cat > slots) begin
                idx_q <= '0;
                quo_q <= {FIELD_W{1'b1}};
            end else begin
                idx_q <= 4'(STEP_CNT);
                quo_q <= '0;
            end
        end else if (ack) begin
            busy_q <= 1'b0;
        end else if (busy_q && idx_q != '0) begin
            idx_q <= idx_q - 4'd1;
            quo_q <= {quo_q[FIELD_W-2:0], fits};
            rem_q <= fits ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
        end
    end

    assign done = busy_q && (idx_q == '0);
    assign quo  = quo_q;

    logic [NW-1:0] den_x255;
    logic [NW-1:0] prod_lo;
    logic [NW-1:0] prod_hi;
    assign den_x255 = {den_q, {FIELD_W{1'b0}}} - {{FIELD_W{1'b0}}, den_q};
    assign prod_lo  = NW'(den_q) * NW'(quo_q);
    assign prod_hi  = prod_lo + NW'(den_q);

    AST_QUO_EXACT: assert property (@(posedge clk) disable iff (rst)
        (done && den_q != '0 && num_q <= den_x255) |-> (prod_lo <= num_q && num_q < prod_hi));  // R4
    AST_QUO_SAT: assert property (@(posedge clk) disable iff (rst)
        (done && den_q != '0 && num_q > den_x255) |-> quo_q == {FIELD_W{1'b1}});  // R5
    AST_ZERO_DEN: assert property (@(posedge clk) disable iff (rst)
        (done && den_q == '0) |-> quo_q == '0);  // R6

endmodule

// File: rtl/topdown_ratio_unit.sv
module topdown_ratio_unit
    import td_pkg::*;
#(
    parameter  int CNT_W = 48,
    localparam int RSP_W = (CNT_W > CAT_N * FIELD_W) ? CNT_W : CAT_N * FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_inc,
    input  logic [CAT_N-1:0]  cat_inc,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [RSP_W-1:0]  rsp_data,
    output logic              ovf_flag
);

    unit_state_e        state_q;
    logic [CNT_W-1:0]   slots_q;
    logic               ovf_q;
    logic               rsp_valid_q;
    logic [RSP_W-1:0]   rsp_data_q;

    op_t                op;
    logic               cat_clr;
    logic               div_ack;
    logic               ovf_clr;
    logic [CNT_W-1:0]   cat_cnt  [CAT_N];
    logic [FIELD_W-1:0] div_quo  [CAT_N];
    logic [CAT_N-1:0]   div_done;
    logic [CAT_N-1:0]   cat_wrap;
    logic [CAT_N*FIELD_W-1:0] packed_fields;

    assign req_ready = (state_q == ST_IDLE);
    assign op        = decode_op(req_valid && req_ready, req_wr, req_addr);
    assign cat_clr   = op.met_rd || op.met_wr;
    assign div_ack   = (state_q == ST_DIV) && (&div_done);
    assign ovf_clr   = op.met_wr || (op.ctl_wr && req_wdata[0]);

    for (genvar i = 0; i < CAT_N; i++) begin : g_cat
        td_event_counter #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .clr  (cat_clr),
            .inc  (cat_inc[i]),
            .cnt  (cat_cnt[i]),
            .wrap (cat_wrap[i])
        );

        td_ratio_div #(.W(CNT_W)) u_div (
            .clk   (clk),
            .rst   (rst),
            .start (op.met_rd),
            .ack   (div_ack),
            .cat   (cat_cnt[i]),
            .slots (slots_q),
            .done  (div_done[i]),
            .quo   (div_quo[i])
        );

        assign packed_fields[i*FIELD_W +: FIELD_W] = div_quo[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (state_q == ST_IDLE && op.met_rd) begin
            state_q <= ST_DIV;
        end else if (div_ack) begin
            state_q <= ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
        end else if (op.slots_wr) begin
            slots_q <= req_wdata;
        end else if (op.met_rd) begin
            slots_q <= CNT_W'(slot_inc);
        end else if (slot_inc) begin
            slots_q <= slots_q + CNT_W'(1);
        end
    end

    // A wrap outranks any clear arriving in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (|cat_wrap) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= op.slots_rd || op.ctl_rd || op.none_rd || div_ack;
            if (op.slots_rd) begin
                rsp_data_q <= RSP_W'(slots_q);
            end else if (op.ctl_rd) begin
                rsp_data_q <= RSP_W'(ovf_q);
            end else if (op.none_rd) begin
                rsp_data_q <= '0;
            end else if (div_ack) begin
                rsp_data_q <= RSP_W'(packed_fields);
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign ovf_flag  = ovf_q;

    AST_SLOTS_LOAD: assert property (@(posedge clk) disable iff (rst)
        op.slots_wr |=> slots_q == $past(req_wdata));  // R3
    AST_SLOTS_RESTART: assert property (@(posedge clk) disable iff (rst)
        op.met_rd |=> slots_q == CNT_W'($past(slot_inc)));  // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr) |=> ovf_q);  // R9
    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (rst)
        (op.met_rd && slots_q == '0) |-> ##2 (rsp_valid_q && rsp_data_q == '0));  // R6
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIV && !div_ack) |=> !rsp_valid_q);  // R11

endmodule

// File: tb/test_topdown_ratio_unit.sv
module test_topdown_ratio_unit;

    localparam int W  = 10;
    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          slot_inc;
    logic [3:0]    cat_inc;
    logic          req_valid;
    logic          req_wr;
    logic [1:0]    req_addr;
    logic [W-1:0]  req_wdata;
    logic          req_ready;
    logic          rsp_valid;
    logic [RW-1:0] rsp_data;
    logic          ovf_flag;

    always #10 clk = ~clk;  // 50 MHz

    topdown_ratio_unit #(.CNT_W(W)) i_topdown_ratio_unit (
        .clk       (clk),
        .rst       (rst),
        .slot_inc  (slot_inc),
        .cat_inc   (cat_inc),
        .req_valid (req_valid),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .ovf_flag  (ovf_flag)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [W-1:0]  m_slots;
    logic [W-1:0]  m_cat [4];
    logic          m_ovf;

    bit            imm_pend;
    logic [RW-1:0] imm_exp;
    string         imm_tag;
    bit            met_pend;
    logic [RW-1:0] met_exp;
    string         met_tag;
    int            met_wait;

    function automatic logic [7:0] ratio(logic [W-1:0] c, logic [W-1:0] s);
        if (s == '0) return 8'h00;
        if (c > s) return 8'hFF;
        return 8'((int'(c) * 255) / int'(s));
    endfunction

    function automatic logic [RW-1:0] model_pack();
        return {ratio(m_cat[3], m_slots), ratio(m_cat[2], m_slots),
                ratio(m_cat[1], m_slots), ratio(m_cat[0], m_slots)};
    endfunction

    task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic [3:0] c, input logic rq, input logic wr,
                        input logic [1:0] a, input logic [W-1:0] wd, input string tag);
        logic acc;
        logic wrapped;
        slot_inc  = s;
        cat_inc   = c;
        req_valid = rq;
        req_wr    = wr;
        req_addr  = a;
        req_wdata = wd;
        acc = rq && req_ready;
        if (acc && !wr) begin
            case (a)
                2'd0: begin imm_pend = 1; imm_exp = RW'(m_slots); imm_tag = tag; end
                2'd2: begin imm_pend = 1; imm_exp = RW'(m_ovf);   imm_tag = tag; end
                2'd3: begin imm_pend = 1; imm_exp = '0;           imm_tag = tag; end
                default: begin met_pend = 1; met_exp = model_pack(); met_tag = tag; met_wait = 0; end
            endcase
        end
        @(posedge clk);
        wrapped = 0;
        for (int i = 0; i < 4; i++) begin
            if (acc && a == 2'd1) m_cat[i] = W'(c[i]);
            else if (c[i]) begin
                if (&m_cat[i]) wrapped = 1;
                m_cat[i] = m_cat[i] + W'(1);
            end
        end
        if (acc && wr && a == 2'd0) m_slots = wd;
        else if (acc && !wr && a == 2'd1) m_slots = W'(s);
        else if (s) m_slots = m_slots + W'(1);
        if (wrapped) m_ovf = 1;
        else if (acc && wr && (a == 2'd1 || (a == 2'd2 && wd[0]))) m_ovf = 0;
        @(negedge clk);
        req_valid = 0;
        slot_inc  = 0;
        cat_inc   = '0;
        if (imm_pend) begin
            chk({imm_tag, " rsp_valid"}, RW'(rsp_valid), 1);
            chk({imm_tag, " read data"}, rsp_data, imm_exp);
            imm_pend = 0;
        end else if (met_pend) begin
            if (rsp_valid) begin
                chk({met_tag, " metrics"}, rsp_data, met_exp);
                met_pend = 0;
            end else begin
                met_wait++;
                if (met_wait > 20) begin
                    chk({met_tag, " metrics timeout"}, 0, 1);
                    met_pend = 0;
                end
            end
        end else if (rsp_valid) begin
            chk({tag, " unexpected rsp_valid"}, 1, 0);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 4'b0, 0, 0, 2'd0, '0, tag);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 25 && met_pend; i++) step(0, 4'b0, 0, 0, 2'd0, '0, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst = 1; slot_inc = 0; cat_inc = '0; req_valid = 0; req_wr = 0; req_addr = '0; req_wdata = '0;
        m_slots = '0; m_ovf = 0; imm_pend = 0; met_pend = 0; met_wait = 0;
        for (int i = 0; i < 4; i++) m_cat[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        chk("R1 req_ready", RW'(req_ready), 1);
        chk("R1 rsp_valid", RW'(rsp_valid), 0);
        chk("R1 ovf_flag", RW'(ovf_flag), 0);
        step(0, 4'b0, 1, 0, 2'd0, '0, "R1 slots");
        step(0, 4'b0, 1, 0, 2'd1, '0, "R1 metrics");
        drain("R1");

        // R2: slot counting
        for (int i = 0; i < 5; i++) step(1, 4'b0, 0, 0, 2'd0, '0, "R2");
        step(0, 4'b0, 1, 0, 2'd0, '0, "R2 slots");

        // R3: load wins over same-cycle strobe
        step(1, 4'b0, 1, 1, 2'd0, W'(100), "R3");
        step(0, 4'b0, 1, 0, 2'd0, '0, "R3 slots");

        // R8: metrics write clears categories, slots untouched
        for (int i = 0; i < 3; i++) step(0, 4'b1111, 0, 0, 2'd0, '0, "R8");
        step(0, 4'b0001, 1, 1, 2'd1, '0, "R8");
        step(0, 4'b0, 1, 0, 2'd0, '0, "R8 slots kept");

        // R4 R5: scaled fields, backend saturates
        step(0, 4'b0, 1, 1, 2'd0, W'(200), "R4");
        for (int i = 0; i < 250; i++)
            step(0, {1'b1, 1'b0, i < 20, i < 50}, 0, 0, 2'd0, '0, "R4");
        chk("R4 R5 model fields", model_pack(), 32'hFF001941);
        step(0, 4'b0, 1, 0, 2'd1, '0, "R4 R5");
        drain("R4");

        // R7 R11: read clears with strobes in the accepting cycle; busy ignores requests
        step(1, 4'b0110, 1, 0, 2'd1, '0, "R7 first");
        chk("R11 req_ready low while dividing", RW'(req_ready), 0);
        step(0, 4'b0, 1, 1, 2'd0, W'(55), "R11");
        drain("R7");
        step(0, 4'b0, 1, 0, 2'd0, '0, "R7 R11 slots");
        step(0, 4'b0, 1, 0, 2'd1, '0, "R7 interval");
        drain("R7");

        // R6: zero slots gives zeros after two cycles
        step(0, 4'b0, 1, 1, 2'd1, '0, "R6");
        step(0, 4'b0, 1, 1, 2'd0, '0, "R6");
        for (int i = 0; i < 3; i++) step(0, 4'b1010, 0, 0, 2'd0, '0, "R6");
        step(0, 4'b0, 1, 0, 2'd1, '0, "R6 zero");
        chk("R6 no response yet", RW'(rsp_valid), 0);
        step(0, 4'b0, 0, 0, 2'd0, '0, "R6");
        chk("R6 response in second cycle", RW'(met_pend), 0);

        // R12: large preload
        step(0, 4'b0, 1, 1, 2'd0, W'(1000), "R12");
        step(0, 4'b0, 1, 1, 2'd1, '0, "R12");
        for (int i = 0; i < 3; i++) step(0, 4'b1111, 0, 0, 2'd0, '0, "R12");
        step(0, 4'b0, 1, 0, 2'd1, '0, "R12 preload");
        drain("R12");

        // R9 R10: overflow flag
        step(0, 4'b0, 1, 1, 2'd1, '0, "R9");
        for (int i = 0; i < 1023; i++) step(0, 4'b1000, 0, 0, 2'd0, '0, "R9");
        chk("R9 no wrap yet", RW'(ovf_flag), 0);
        step(0, 4'b1000, 0, 0, 2'd0, '0, "R9");
        chk("R9 wrap sets flag", RW'(ovf_flag), 1);
        idle(5, "R9");
        chk("R9 sticky", RW'(ovf_flag), 1);
        step(0, 4'b0, 1, 0, 2'd2, '0, "R10 ctrl read");
        step(0, 4'b0, 1, 1, 2'd2, W'(2), "R10");
        chk("R10 bit0 clear keeps flag", RW'(ovf_flag), 1);
        step(0, 4'b0, 1, 1, 2'd2, W'(1), "R10");
        chk("R10 clear", RW'(ovf_flag), 0);
        step(0, 4'b0, 1, 0, 2'd3, '0, "R10 unused addr");
        for (int i = 0; i < 1023; i++) step(0, 4'b1000, 0, 0, 2'd0, '0, "R9");
        step(0, 4'b1000, 1, 1, 2'd2, W'(1), "R9 collision");
        chk("R9 wrap beats clear", RW'(ovf_flag), 1);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic s;
            logic [3:0] c;
            logic rq;
            s = ($urandom % 8) != 0;
            for (int k = 0; k < 4; k++) c[k] = ($urandom % 4) == 0;
            rq = !met_pend && (($urandom % 32) == 0);
            step(s, c, rq, 1'($urandom % 2), 2'($urandom % 4), W'($urandom), "R4 R7 R9 random");
            if (n % 16 == 0) chk("R9 random flag", RW'(ovf_flag), RW'(m_ovf));
        end
        drain("random");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule